// File: doc/BRIEF.md
# Fractional Master-Clock Divider

This block takes an incoming audio master clock and gives each of its output channels a clock that is either the master clock unchanged or the master clock divided by 2.0 or by 1.5. The divider lets a master clock faster than 256Fs be brought down to 256Fs. With the default of two channels, channel 0 clocks the internal TDM logic and channel 1 clocks an external converter, which may be fed a master clock above 25 MHz. The two channels run independently.

Each channel has an enable bit and a ratio bit. With the enable bit clear the channel passes the master clock through. With it set, the ratio bit picks division by 1.5 (ratio 0) or by 2.0 (ratio 1). Both dividers run all the time. A selector clocked on the falling edge of the master clock moves a channel to a new mode only at a falling edge after which both the old output and the new output stay low. As a result, a change of the control bits never produces a shortened pulse.

The divide-by-2 path is a toggle flop on the rising edge. The divide-by-1.5 path uses a three-state ring on the rising edge and two flops on the falling edge. Together they give two output periods for every three input periods.

Top module: `mclk_frac_div`

## Requirements
- R1: While rst_n is low, and after it is released with div_en[i]=0, clk_out[i] equals mclk: high in the high phase of mclk and low in its low phase.
- R2: With div_en[i]=0 held steady, clk_out[i] has the period of mclk (10 ns at 100 MHz) and is high for half of it.
- R3: With div_en[i]=1 and div_by2[i]=1 held steady, clk_out[i] has a period of two mclk periods and is high for exactly one mclk period.
- R4: With div_en[i]=1 and div_by2[i]=0 held steady, clk_out[i] has a period of 1.5 mclk periods (two rising edges every three mclk periods). Each high pulse lasts half an mclk period, so the duty cycle is within half an mclk period of 50 percent.
- R5: While div_en[i]=0, toggling div_by2[i] has no effect: clk_out[i] keeps following mclk with no change of period or phase.
- R6: A new setting of div_en[i] or div_by2[i] held steady takes effect within 8 mclk periods. Throughout any change, no high or low phase of clk_out[i] is shorter than half an mclk period.
- R7: Channels are independent: changing the controls of one channel leaves the period and pulse width of every other channel's output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Incoming audio master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_en | input | NCH | Per channel: 1 divides, 0 passes mclk through (bit i is channel i) |
| div_by2 | input | NCH | Per channel ratio: 1 divides by 2.0, 0 divides by 1.5 (bit i is channel i) |
| clk_out | output | NCH | Per channel output clock |

## Verification
The bench builds the block with NCH=2, the default, so the TDM channel and the converter channel are both present. This lets every row of the stimulus table move one channel between modes while the other holds or changes too, which makes R7 observable as an unchanged period on the quiet channel. Edge times are taken in real time on both output edges. This exposes the half-period timing of the divide-by-1.5 pulses and any shortened phase during a mode change.

// File: rtl/mfd_pkg.sv
`timescale 1ns/1ps
package mfd_pkg;
  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_DIV15 = 2'd1,
    MODE_DIV2  = 2'd2
  } mode_t;

  // Ring length of the 1.5 divider: three input periods per two output periods
  localparam int RING_LEN = 3;

  function automatic mode_t decode_mode(input logic en, input logic by2);
    if (!en)     return MODE_PASS;
    else if (by2) return MODE_DIV2;
    else          return MODE_DIV15;
  endfunction
endpackage

// File: rtl/mfd_dividers.sv
`timescale 1ns/1ps
module mfd_dividers
  import mfd_pkg::*;
(
  input  logic mclk,
  input  logic rst_n,
  output logic div15_clk,
  output logic div2_clk,
  output logic div15_quiet,
  output logic div2_quiet
);
  logic [RING_LEN-1:0] phase_ring;
  logic                fall_a;
  logic                fall_b;
  logic                tog;

  // one-hot phase ring, rotating once per input period
  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) phase_ring <= {1'b1, {(RING_LEN-1){1'b0}}};
    else        phase_ring <= {phase_ring[RING_LEN-2:0], phase_ring[RING_LEN-1]};
  end

  // falling-edge copies of the first two phases
  always_ff @(negedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      fall_a <= 1'b0;
      fall_b <= 1'b0;
    end else begin
      fall_a <= phase_ring[0];
      fall_b <= phase_ring[1];
    end
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else        tog <= ~tog;
  end

  // high for the first half of phase 0 and the second half of phase 1
  assign div15_clk   = (phase_ring[0] & ~fall_a) | (phase_ring[1] & fall_b);
  assign div2_clk    = tog;
  // output stays low from the coming falling edge to the next rising edge
  assign div15_quiet = ~phase_ring[1];
  assign div2_quiet  = ~tog;
endmodule

// File: rtl/mfd_glitchless_sel.sv
`timescale 1ns/1ps
module mfd_glitchless_sel
  import mfd_pkg::*;
(
  input  logic  mclk,
  input  logic  rst_n,
  input  mode_t req_mode,
  input  logic  div15_clk,
  input  logic  div2_clk,
  input  logic  div15_quiet,
  input  logic  div2_quiet,
  output logic  clk_sel
);
  mode_t cur_mode;

  function automatic logic is_quiet(input mode_t m, input logic q15, input logic q2);
    case (m)
      MODE_DIV15: return q15;
      MODE_DIV2:  return q2;
      default:    return 1'b1;
    endcase
  endfunction

  logic may_switch;
  assign may_switch = (req_mode != cur_mode)
                    && is_quiet(cur_mode, div15_quiet, div2_quiet)
                    && is_quiet(req_mode, div15_quiet, div2_quiet);

  always_ff @(negedge mclk or negedge rst_n) begin
    if (!rst_n)          cur_mode <= MODE_PASS;
    else if (may_switch) cur_mode <= req_mode;
  end

  always_comb begin
    case (cur_mode)
      MODE_DIV15: clk_sel = div15_clk;
      MODE_DIV2:  clk_sel = div2_clk;
      default:    clk_sel = mclk;
    endcase
  end
endmodule

// File: rtl/mclk_frac_div.sv
`timescale 1ns/1ps
module mclk_frac_div
  import mfd_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           mclk,
  input  logic           rst_n,
  input  logic [NCH-1:0] div_en,
  input  logic [NCH-1:0] div_by2,
  output logic [NCH-1:0] clk_out
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic  d15, d2, q15, q2;
    mode_t want;

    assign want = decode_mode(div_en[c], div_by2[c]);

    mfd_dividers u_div (
      .mclk        (mclk),
      .rst_n       (rst_n),
      .div15_clk   (d15),
      .div2_clk    (d2),
      .div15_quiet (q15),
      .div2_quiet  (q2)
    );

    mfd_glitchless_sel u_sel (
      .mclk        (mclk),
      .rst_n       (rst_n),
      .req_mode    (want),
      .div15_clk   (d15),
      .div2_clk    (d2),
      .div15_quiet (q15),
      .div2_quiet  (q2),
      .clk_sel     (clk_out[c])
    );
  end
endmodule

// File: rtl/mclk_frac_div_chk.sv
`timescale 1ns/1ps
module mclk_frac_div_chk #(
  parameter int NCH = 2
) (
  input logic           mclk,
  input logic           rst_n,
  input logic [NCH-1:0] div_en,
  input logic [NCH-1:0] div_by2,
  input logic [NCH-1:0] clk_out
);
  localparam int AGE_W   = 4;
  localparam int SETTLED = 12;

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic [AGE_W-1:0] age;
    logic [1:0]       ctl_q;
    logic             settled;

    always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
        age   <= '0;
        ctl_q <= 2'b00;
      end else begin
        ctl_q <= {div_by2[c], div_en[c]};
        if ({div_by2[c], div_en[c]} != ctl_q) age <= '0;
        else if (age != {AGE_W{1'b1}})        age <= age + 1'b1;
      end
    end

    assign settled = (age >= AGE_W'(SETTLED)) && ({div_by2[c], div_en[c]} == ctl_q);

    // R2: pass-through is high in the mclk high phase, low in the low phase
    a_r2_pass_high: assert property (@(negedge mclk) disable iff (!rst_n)
      settled && !div_en[c] |-> clk_out[c]);
    a_r2_pass_low: assert property (@(posedge mclk) disable iff (!rst_n)
      settled && !div_en[c] |-> !clk_out[c]);

    // R3: divide by 2 flips level every input period in both phases
    a_r3_div2_flip_low: assert property (@(posedge mclk) disable iff (!rst_n)
      settled && div_en[c] && div_by2[c] |-> clk_out[c] != $past(clk_out[c]));
    a_r3_div2_flip_high: assert property (@(negedge mclk) disable iff (!rst_n)
      settled && div_en[c] && div_by2[c] |-> clk_out[c] != $past(clk_out[c]));

    // R4: divide by 1.5 is high in exactly one of three consecutive half phases
    a_r4_div15_hi_phase: assert property (@(negedge mclk) disable iff (!rst_n)
      settled && div_en[c] && !div_by2[c] |->
        $countones({clk_out[c], $past(clk_out[c]), $past(clk_out[c], 2)}) == 1);
    a_r4_div15_lo_phase: assert property (@(posedge mclk) disable iff (!rst_n)
      settled && div_en[c] && !div_by2[c] |->
        $countones({clk_out[c], $past(clk_out[c]), $past(clk_out[c], 2)}) == 1);
  end
endmodule

bind mclk_frac_div mclk_frac_div_chk #(.NCH(NCH)) u_chk (
  .mclk    (mclk),
  .rst_n   (rst_n),
  .div_en  (div_en),
  .div_by2 (div_by2),
  .clk_out (clk_out)
);

// File: tb/mclk_frac_div_test.sv
`timescale 1ns/1ps
module mclk_frac_div_test;
  localparam int NCH = 2;
  localparam int NV  = 7;
  // control word {div_by2[1], div_en[1], div_by2[0], div_en[0]}
  localparam logic [3:0] V_CTRL [NV] = '{4'b0000, 4'b0001, 4'b0111, 4'b1110, 4'b1101, 4'b0111, 4'b1000};
  localparam int V_P0 [NV] = '{10, 15, 20, 10, 15, 20, 10};
  localparam int V_H0 [NV] = '{ 5,  5, 10,  5,  5, 10,  5};
  localparam int V_P1 [NV] = '{10, 10, 15, 20, 20, 15, 10};
  localparam int V_H1 [NV] = '{ 5,  5,  5, 10, 10,  5,  5};

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] div_en = '0;
  logic [NCH-1:0] div_by2 = '0;
  logic [NCH-1:0] clk_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mclk_frac_div #(.NCH(NCH)) uut (
    .mclk(clk), .rst_n(rst_n), .div_en(div_en), .div_by2(div_by2), .clk_out(clk_out)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_mon
    realtime t_rise = 0;
    realtime t_edge = 0;
    real per_ns = 0;
    real hi_ns = 0;
    int runts = 0;
    int rises = 0;
    bit seen = 0;
    always @(posedge clk_out[g]) begin
      if (rst_n && seen && ($realtime - t_edge) < 4.9) runts++;
      if (seen) per_ns = $realtime - t_rise;
      t_rise = $realtime;
      t_edge = $realtime;
      seen = 1;
      rises++;
    end
    always @(negedge clk_out[g]) begin
      if (rst_n && seen && ($realtime - t_edge) < 4.9) runts++;
      hi_ns = $realtime - t_rise;
      t_edge = $realtime;
    end
  end

  task automatic chk(input string what, input real act, input real exp);
    checks++;
    if (act - exp > 0.1 || exp - act > 0.1) begin
      errors++;
      $display("FAIL %s actual %0.2f expected %0.2f", what, act, exp);
    end
  endtask

  task automatic set_ctrl(input logic [3:0] w);
    {div_by2[1], div_en[1], div_by2[0], div_en[0]} = w;
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int mism;
    int r_start;
    // R1: during reset the outputs follow mclk
    repeat (3) @(posedge clk);
    #2 chk("R1 reset high phase ch0", real'(clk_out[0]), 1.0);
    chk("R1 reset high phase ch1", real'(clk_out[1]), 1.0);
    @(negedge clk); #2 chk("R1 reset low phase", real'(clk_out), 0.0);
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (6) @(posedge clk); #1;
    chk("R1 after reset period ch0", g_mon[0].per_ns, 10.0);
    chk("R1 after reset period ch1", g_mon[1].per_ns, 10.0);

    // table: R2 R3 R4 R7 across mode pairs
    for (int i = 0; i < NV; i++) begin
      @(posedge clk); #2 set_ctrl(V_CTRL[i]);
      repeat (20) @(posedge clk); #1;
      chk($sformatf("R2 R3 R4 R7 row %0d period ch0", i), g_mon[0].per_ns, real'(V_P0[i]));
      chk($sformatf("R2 R3 R4 R7 row %0d high ch0", i),   g_mon[0].hi_ns,  real'(V_H0[i]));
      chk($sformatf("R2 R3 R4 R7 row %0d period ch1", i), g_mon[1].per_ns, real'(V_P1[i]));
      chk($sformatf("R2 R3 R4 R7 row %0d high ch1", i),   g_mon[1].hi_ns,  real'(V_H1[i]));
    end

    // R5: ratio toggling while disabled, output must keep following mclk
    @(posedge clk); #2 set_ctrl(4'b0000);
    repeat (10) @(posedge clk);
    mism = 0;
    for (int k = 0; k < 30; k++) begin
      @(posedge clk); #2;
      if (k % 3 == 0) div_by2[0] = ~div_by2[0];
      if (clk_out[0] !== 1'b1) mism++;
      @(negedge clk); #2;
      if (clk_out[0] !== 1'b0) mism++;
    end
    chk("R5 phase mismatches while ratio toggles", real'(mism), 0.0);
    chk("R5 period while ratio toggles", g_mon[0].per_ns, 10.0);

    // R6: latency bypass -> divide by 2 on ch1
    @(posedge clk); #2 set_ctrl(4'b1100);
    repeat (8) @(posedge clk); #1;
    r_start = g_mon[1].rises;
    repeat (8) @(posedge clk); #1;
    chk("R6 div2 rises in 8 periods after 8-cycle settle", real'(g_mon[1].rises - r_start), 4.0);

    // R6: latency divide by 2 -> divide by 1.5 on ch1
    @(posedge clk); #2 set_ctrl(4'b0100);
    repeat (8) @(posedge clk); #1;
    r_start = g_mon[1].rises;
    repeat (12) @(posedge clk); #1;
    chk("R6 div1.5 rises in 12 periods after 8-cycle settle", real'(g_mon[1].rises - r_start), 8.0);

    // R6: no shortened phase anywhere in the run
    repeat (4) @(posedge clk);
    chk("R6 short pulses ch0", real'(g_mon[0].runts), 0.0);
    chk("R6 short pulses ch1", real'(g_mon[1].runts), 0.0);

    done = 1;
    summary();
    $finish;
  end
endmodule